// File: doc/BRIEF.md
# DS3 Overhead Error Injector

This block sits on the serial transmit path after the frame builder. It receives one bit per clock enable, together with strobes that mark where the frame starts and where the multiframe alignment (M), subframe alignment (F), frame parity (P) and path parity (C-parity) bits fall. It forwards the stream with a fixed delay of one clock enable. On request, it corrupts selected overhead bits so that the far end's error detectors can be tested.

Framing errors come in four shapes: one F bit, one M bit, a whole subframe of F bits, or one M bit in each of two consecutive frames. Both parity groups can be corrupted for a single frame on request, or in every frame while a continuous flag is held. A single request is stored and takes effect at the next frame boundary. When the corrupted frame or frames have left the block, it gives a one-cycle done pulse. It never changes payload bits.

Top module: `ds3_oh_err_inject`

## Requirements
- R1: After a synchronous active-low reset, `out_bit`, `fe_done`, `p_done` and `c_done` are all 0.
- R2: On each clock with `ce` high, `out_bit` takes the value of `in_bit` from that clock, changed only as R3 to R9 describe, so bits that carry no position strobe pass unchanged. On clocks with `ce` low, `out_bit` holds its value.
- R3: With `fe_mode` = 2'b00, the frame after a `fe_req` pulse has its first F-marked bit inverted, and no other bit of that frame is inverted.
- R4: With `fe_mode` = 2'b01, the frame after the request has its first M-marked bit inverted, and no other bit of that frame is inverted.
- R5: With `fe_mode` = 2'b10, the frame after the request has its first four F-marked bits (one subframe) inverted.
- R6: With `fe_mode` = 2'b11, the first M-marked bit is inverted in each of the two frames that follow the request.
- R7: A `p_req` pulse inverts every P-marked bit in the next frame, and only in that frame.
- R8: A `c_req` pulse inverts every C-parity-marked bit in the next frame, and only in that frame.
- R9: The value of `p_cont` or `c_cont` at a frame-start clock enable decides whether every P-marked or C-parity-marked bit of that frame is inverted.
- R10: `fe_done`, `p_done` and `c_done` each pulse high for exactly one clock, on the clock where the first bit of the frame after the last affected frame is registered to `out_bit`. Continuous mode gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Bit enable; one stream bit per high cycle |
| in_bit | input | 1 | Incoming stream bit |
| frame_start | input | 1 | Marks the first bit of a frame |
| m_pos | input | 1 | Marks a multiframe alignment bit |
| f_pos | input | 1 | Marks a subframe alignment bit |
| p_pos | input | 1 | Marks a P parity bit |
| cpar_pos | input | 1 | Marks a C-parity bit |
| fe_mode | input | 2 | Framing error shape: 00 one F, 01 one M, 10 subframe, 11 two-frame M |
| fe_req | input | 1 | Framing error request pulse |
| p_req | input | 1 | Single P parity error request pulse |
| c_req | input | 1 | Single C-parity error request pulse |
| p_cont | input | 1 | Continuous P parity corruption |
| c_cont | input | 1 | Continuous C-parity corruption |
| out_bit | output | 1 | Outgoing stream bit, one enable later |
| fe_done | output | 1 | Framing error insertion finished |
| p_done | output | 1 | Single P error finished |
| c_done | output | 1 | Single C-parity error finished |

## Verification
The stream uses a short frame with fixed strobe positions and random payload bits, with `ce` gaps placed at random and one long stall. The first four framing requests step through the shapes in order. After that the shapes are drawn at random, so the one-F, subframe, one-M and two-frame cases show whether the right count of the right kind of bit was inverted. Single parity requests are mixed with continuous flags that toggle mid-frame. This shows whether a flag is sampled at the frame boundary, and whether a single request is applied to exactly one frame when the continuous flag already covers it. The done pulses are compared on every clock, so a pulse that comes a frame early or late, or comes at all in continuous mode, is caught.

// File: rtl/ds3_oh_pkg.sv
// Shared types for the DS3 overhead error injector.
// Assumes: framing error shape is encoded in two bits, as the top port documents.
package ds3_oh_pkg;

    typedef enum logic [1:0] {
        FE_ONE_F   = 2'b00,
        FE_ONE_M   = 2'b01,
        FE_SUBFRM  = 2'b10,
        FE_TWO_M   = 2'b11
    } fe_mode_e;

endpackage

// File: rtl/oh_frame_err.sv
// Framing error sequencer.
// Holds a framing error request until the next frame start, then decides which
// F or M positions of the following frame (two frames for the double-M shape) to invert.
// Assumes: position strobes are mutually exclusive and only valid with ce.
module oh_frame_err
    import ds3_oh_pkg::*;
#(
    parameter int F_PER_SF = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce,
    input  logic     frame_start,
    input  logic     is_m,
    input  logic     is_f,
    input  logic     req,
    input  fe_mode_e mode,
    output logic     flip,
    output logic     done
);
    localparam int FCW = $clog2(F_PER_SF + 1);
    localparam logic [FCW-1:0] FMAX = FCW'(F_PER_SF);

    logic           pending;
    fe_mode_e       req_mode;
    logic           active;
    fe_mode_e       act_mode;
    logic           more_frame;
    logic [FCW-1:0] f_cnt;
    logic           m_seen;

    logic           at_fs;
    logic           start;
    logic           cur_active;
    fe_mode_e       cur_mode;
    logic [FCW-1:0] cur_fcnt;
    logic           cur_mseen;

    // Frame-boundary decisions: start a stored request or continue a two-frame shape.
    always_comb begin
        at_fs      = ce && frame_start;
        start      = at_fs && pending && (!active || !more_frame);
        cur_active = at_fs ? (start || (active && more_frame)) : active;
        cur_mode   = start ? req_mode : act_mode;
        cur_fcnt   = at_fs ? '0 : f_cnt;
        cur_mseen  = at_fs ? 1'b0 : m_seen;
    end

    // Select the bit to invert for the current position.
    always_comb begin
        flip = 1'b0;
        if (ce && cur_active) begin
            unique case (cur_mode)
                FE_ONE_F:  flip = is_f && (cur_fcnt == '0);
                FE_SUBFRM: flip = is_f && (cur_fcnt < FMAX);
                FE_ONE_M,
                FE_TWO_M:  flip = is_m && !cur_mseen;
                default:   flip = 1'b0;
            endcase
        end
    end

    // State update: request store, frame tracking and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            req_mode   <= FE_ONE_F;
            active     <= 1'b0;
            act_mode   <= FE_ONE_F;
            more_frame <= 1'b0;
            f_cnt      <= '0;
            m_seen     <= 1'b0;
            done       <= 1'b0;
        end else begin
            done    <= at_fs && active && !more_frame;
            pending <= req || (pending && !start);
            if (req) begin
                req_mode <= mode;
            end
            if (ce) begin
                active <= cur_active;
                if (start) begin
                    act_mode   <= req_mode;
                    more_frame <= (req_mode == FE_TWO_M);
                end else if (at_fs) begin
                    more_frame <= 1'b0;
                end
                f_cnt  <= (is_f && cur_fcnt != FMAX) ? cur_fcnt + 1'b1 : cur_fcnt;
                m_seen <= cur_mseen || is_m;
            end
        end
    end

endmodule

// File: rtl/oh_parity_err.sv
// Parity error unit for one group of parity positions.
// A single request is held until the next frame start and corrupts that whole frame.
// The continuous flag, sampled at each frame start, corrupts the frame it starts.
// Assumes: is_pos is only meaningful when ce is high.
module oh_parity_err (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic frame_start,
    input  logic is_pos,
    input  logic req,
    input  logic cont,
    output logic flip,
    output logic done
);
    logic pending;
    logic active;
    logic single_q;
    logic at_fs;
    logic cur_active;

    // Frame-level enable, taking effect on the frame-start bit itself.
    always_comb begin
        at_fs      = ce && frame_start;
        cur_active = at_fs ? (pending || cont) : active;
        flip       = ce && cur_active && is_pos;
    end

    // Request store, frame enable and done pulse for single requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            active   <= 1'b0;
            single_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            pending <= req || (pending && !at_fs);
            done    <= at_fs && single_q;
            if (at_fs) begin
                single_q <= pending;
                active   <= pending || cont;
            end
        end
    end

endmodule

// File: rtl/ds3_oh_err_inject.sv
// DS3 overhead error injector top.
// Forwards the serial stream with one clock-enable delay and inverts selected
// overhead bits on request: framing shapes and two parity groups.
// Assumes: position strobes are mutually exclusive and valid with ce.
module ds3_oh_err_inject
    import ds3_oh_pkg::*;
#(
    parameter int F_PER_SF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       in_bit,
    input  logic       frame_start,
    input  logic       m_pos,
    input  logic       f_pos,
    input  logic       p_pos,
    input  logic       cpar_pos,
    input  logic [1:0] fe_mode,
    input  logic       fe_req,
    input  logic       p_req,
    input  logic       c_req,
    input  logic       p_cont,
    input  logic       c_cont,
    output logic       out_bit,
    output logic       fe_done,
    output logic       p_done,
    output logic       c_done
);
    localparam int NPAR = 2;

    logic            fe_flip;
    logic [NPAR-1:0] par_pos;
    logic [NPAR-1:0] par_req;
    logic [NPAR-1:0] par_cont;
    logic [NPAR-1:0] par_flip;
    logic [NPAR-1:0] par_done;

    assign par_pos  = {cpar_pos, p_pos};
    assign par_req  = {c_req, p_req};
    assign par_cont = {c_cont, p_cont};
    assign p_done   = par_done[0];
    assign c_done   = par_done[1];

    oh_frame_err #(.F_PER_SF(F_PER_SF)) u_fe (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (ce),
        .frame_start (frame_start),
        .is_m        (m_pos),
        .is_f        (f_pos),
        .req         (fe_req),
        .mode        (fe_mode_e'(fe_mode)),
        .flip        (fe_flip),
        .done        (fe_done)
    );

    for (genvar g = 0; g < NPAR; g++) begin : g_par
        oh_parity_err u_par (
            .clk         (clk),
            .rst_n       (rst_n),
            .ce          (ce),
            .frame_start (frame_start),
            .is_pos      (par_pos[g]),
            .req         (par_req[g]),
            .cont        (par_cont[g]),
            .flip        (par_flip[g]),
            .done        (par_done[g])
        );
    end

    // Output register: one enable of latency, with the selected inversions applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit <= 1'b0;
        end else if (ce) begin
            out_bit <= in_bit ^ fe_flip ^ (^par_flip);
        end
    end

endmodule

// Protocol checker for the injector, bound to every instance of the top.
module oh_inject_chk (
    input logic clk,
    input logic rst_n,
    input logic ce,
    input logic in_bit,
    input logic frame_start,
    input logic m_pos,
    input logic f_pos,
    input logic p_pos,
    input logic cpar_pos,
    input logic out_bit,
    input logic fe_done,
    input logic p_done,
    input logic c_done
);
    AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(out_bit)); // R2
    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !m_pos && !f_pos && !p_pos && !cpar_pos) |=> (out_bit == $past(in_bit))); // R2
    AST_FE_DONE_AT_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_done) |-> $past(ce && frame_start)); // R10
    AST_P_DONE_AT_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_done) |-> $past(ce && frame_start)); // R10
    AST_C_DONE_AT_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_done) |-> $past(ce && frame_start)); // R10
    AST_FE_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fe_done |=> !fe_done); // R10
endmodule

bind ds3_oh_err_inject oh_inject_chk u_chk (.*);

// File: tb/ds3_oh_err_inject_tb.sv
module ds3_oh_err_inject_tb;
    localparam int FLEN    = 56;
    localparam int NFRAMES = 200;

    logic clk = 1'b0;
    logic rst_n, ce, in_bit, frame_start, m_pos, f_pos, p_pos, cpar_pos;
    logic [1:0] fe_mode;
    logic fe_req, p_req, c_req, p_cont, c_cont;
    logic out_bit, fe_done, p_done, c_done;

    int checks = 0;
    int errs   = 0;
    bit finished = 0;

    int fe_plan [0:511];
    bit fe_two2 [0:511];
    bit fe_last [0:511];
    bit ps_req  [0:511];
    bit cs_req  [0:511];
    bit pflip   [0:511];
    bit cflip   [0:511];
    bit pcont_f [0:511];
    bit ccont_f [0:511];

    always #2 clk = ~clk;

    ds3_oh_err_inject u_dut (.*);

    function automatic bit pos_f(int i); return (i % 7) == 3; endfunction
    function automatic bit pos_m(int i); return i == 1 || i == 22 || i == 43; endfunction
    function automatic bit pos_p(int i); return i == 8 || i == 29; endfunction
    function automatic bit pos_c(int i); return i == 15 || i == 36 || i == 50; endfunction

    // Expected framing inversion for bit i of frame f, from R3..R6.
    function automatic bit fe_exp(int f, int i);
        if (fe_two2[f]) return i == 1;
        case (fe_plan[f])
            0: return i == 3;
            1: return i == 1;
            2: return i == 3 || i == 10 || i == 17 || i == 24;
            3: return i == 1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string fe_tag(int f);
        if (fe_two2[f]) return "R6";
        case (fe_plan[f])
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit act, bit exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    initial begin
        int idx, fn, fe_free, fe_cnt, stall;
        bit exp_out, e_fd, e_pd, e_cd, have;
        string tag;
        void'($urandom(32'd4242));
        for (int k = 0; k < 512; k++) begin
            fe_plan[k] = -1; fe_two2[k] = 0; fe_last[k] = 0; ps_req[k] = 0; cs_req[k] = 0;
            pflip[k] = 0; cflip[k] = 0; pcont_f[k] = 0; ccont_f[k] = 0;
        end
        rst_n = 0; ce = 0; in_bit = 0; frame_start = 0; m_pos = 0; f_pos = 0; p_pos = 0;
        cpar_pos = 0; fe_mode = 0; fe_req = 0; p_req = 0; c_req = 0; p_cont = 0; c_cont = 0;
        repeat (4) @(negedge clk);
        chk(out_bit, 1'b0, "R1", "out_bit after reset");
        chk(fe_done, 1'b0, "R1", "fe_done after reset");
        chk(p_done, 1'b0, "R1", "p_done after reset");
        chk(c_done, 1'b0, "R1", "c_done after reset");
        rst_n = 1;
        idx = 0; fn = 0; fe_free = 1; fe_cnt = 0; stall = 0;
        exp_out = 0; e_fd = 0; e_pd = 0; e_cd = 0; have = 0; tag = "R2";
        while (fn < NFRAMES) begin
            if (have) begin
                chk(out_bit, exp_out, tag, "out_bit");
                chk(fe_done, e_fd, "R10", "fe_done");
                chk(p_done, e_pd, "R10", "p_done");
                chk(c_done, e_cd, "R10", "c_done");
            end
            have = 1;
            fe_req = 0; p_req = 0; c_req = 0;
            e_fd = 0; e_pd = 0; e_cd = 0;
            if (fn == 5 && idx == 20 && stall == 0) stall = 25;
            if (stall > 0) begin
                stall--;
                ce = 0;
                if (stall == 0) stall = -1;
            end else begin
                ce = ($urandom % 10) < 7;
            end
            in_bit = $urandom % 2;
            frame_start = (idx == 0);
            m_pos = pos_m(idx); f_pos = pos_f(idx); p_pos = pos_p(idx); cpar_pos = pos_c(idx);
            if (!ce) begin
                tag = "R2";
            end else begin
                bit fl, pf, cf;
                if (idx == 0) begin
                    fn++;
                    pflip[fn] = ps_req[fn] | p_cont; pcont_f[fn] = p_cont;
                    cflip[fn] = cs_req[fn] | c_cont; ccont_f[fn] = c_cont;
                    e_fd = fe_last[fn-1]; e_pd = ps_req[fn-1]; e_cd = cs_req[fn-1];
                end
                pf = pflip[fn] && pos_p(idx);
                cf = cflip[fn] && pos_c(idx);
                fl = fe_exp(fn, idx);
                exp_out = in_bit ^ fl ^ pf ^ cf;
                if (fl) tag = fe_tag(fn);
                else if (pf) tag = pcont_f[fn] ? "R9" : "R7";
                else if (cf) tag = ccont_f[fn] ? "R9" : "R8";
                else tag = "R2";
                if (idx == 30) begin
                    if (fe_free <= fn + 1 && ($urandom % 3) != 0) begin
                        int md = (fe_cnt < 4) ? fe_cnt : int'($urandom % 4);
                        fe_cnt++;
                        fe_mode = md[1:0]; fe_req = 1;
                        fe_plan[fn+1] = md;
                        if (md == 3) begin
                            fe_two2[fn+2] = 1; fe_last[fn+2] = 1; fe_free = fn + 3;
                        end else begin
                            fe_last[fn+1] = 1; fe_free = fn + 2;
                        end
                    end
                    if (($urandom % 3) == 0) begin p_req = 1; ps_req[fn+1] = 1; end
                    if (($urandom % 3) == 0) begin c_req = 1; cs_req[fn+1] = 1; end
                end
                if (idx == 40) begin
                    if (($urandom % 4) == 0) p_cont = ~p_cont;
                    if (($urandom % 4) == 0) c_cont = ~c_cont;
                end
                idx = (idx == FLEN - 1) ? 0 : idx + 1;
            end
            @(negedge clk);
        end
        chk(out_bit, exp_out, tag, "out_bit final");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end
endmodule